// File: doc/BRIEF.md
# Global Validation Trigger Generator

This block lives in the module that directs the whole acquisition system and decides, every clock, whether the system-wide validation trigger is raised. Its inputs are the per-crate ORs of paired-detector coincidence triggers, the single-channel fast triggers of its own channels, and one pairwise coincidence trigger for each adjacent channel pair. A per-channel type map tags each channel as unused, timing (beta), valid, neutron or gamma. From these the block forms several terms:

- an OR of the qualified beta pair triggers;
- one OR for each of the beta, valid and neutron classes;
- the AND of the beta and valid ORs;
- a global OR across all crates.

A two-bit source select picks which beta-derived term acts as the beta validation signal. A two-bit logic-type field then picks one of two trigger equations. The result is registered once and fanned out to every module, which uses it to validate local data capture. Gamma channels are mapped so that the equations can ignore them, and they never reach the output.

Top module: `glob_vtrig_gen`

## Requirements
- R1: `global_trig` is 0 while `rst_n` is low. It is a registered output: the value seen after a rising clock edge reflects the inputs sampled at that edge, so there is one cycle of latency.
- R2: The type of channel i is the 3-bit field `det_map[3*i+2:3*i]`. The codes are 0 none, 1 beta, 2 valid, 3 neutron and 4 gamma, and codes 5 to 7 act as none. A single trigger feeds a class OR only when its channel carries that class code.
- R3: Pair trigger `beta_pair[p]` covers channels 2p and 2p+1. It counts toward the beta pairwise OR only when both of those channels are mapped beta.
- R4: The global coincidence term is the OR of every bit of `crate_coinc_or`.
- R5: `beta_src` selects the beta validation term. Code 0 selects the beta pairwise OR, code 1 the beta single OR, and code 2 the AND of the beta single OR and the valid single OR. Code 3 behaves as code 0.
- R6: Type A: the next output is (global coincidence OR neutron OR) AND the selected beta validation term.
- R7: Type B is selected by `logic_mode` = 2'b01 (bit 0 set, bit 1 clear). The next output is beta single OR AND valid single OR AND (global coincidence OR neutron OR), and `beta_src` has no effect.
- R8: `logic_mode` codes 2'b00, 2'b10 and 2'b11 all select Type A.
- R9: Triggers on channels mapped gamma (or none, or codes 5 to 7) never change `global_trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crate_coinc_or | input | NUM_CRATES | Paired-detector coincidence OR from each crate |
| chan_single | input | NUM_CH | Single fast trigger per local channel |
| beta_pair | input | NUM_CH/2 | Pairwise coincidence trigger per adjacent channel pair |
| det_map | input | 3*NUM_CH | Detector type code per channel |
| logic_mode | input | 2 | Trigger equation select |
| beta_src | input | 2 | Beta validation source select |
| global_trig | output | 1 | Registered global validation trigger |

## Verification
The bench builds the block with NUM_CH = 16 and NUM_CRATES = 3. With these values one channel map can hold every class code, including a reserved code, on distinct channels. It can also place pairs that are fully beta, pairs that are half beta and pairs that are valid-only side by side. Three crate inputs make it possible to show that any single crate, and not only the first, raises the coincidence term. A behavioural model in the bench counts hits per class with integers and predicts each cycle's output. Directed cases cover each select code and each mode code, and a long run of varied patterns follows.

// File: rtl/gvt_pkg.sv
package gvt_pkg;
  localparam int DET_W = 3;

  typedef enum logic [DET_W-1:0] {
    DET_NONE    = 3'd0,
    DET_BETA    = 3'd1,
    DET_VALID   = 3'd2,
    DET_NEUTRON = 3'd3,
    DET_GAMMA   = 3'd4
  } det_e;

  typedef enum logic [1:0] {
    LT_A_ZERO = 2'b00,
    LT_B      = 2'b01,
    LT_RSV    = 2'b10,
    LT_A_ONE  = 2'b11
  } ltype_e;

  typedef enum logic [1:0] {
    BS_PAIR   = 2'd0,
    BS_SINGLE = 2'd1,
    BS_BV_AND = 2'd2,
    BS_RSV    = 2'd3
  } bsrc_e;

  typedef struct packed {
    logic pair_or;
    logic beta_or;
    logic valid_or;
    logic bv_and;
    logic neutron_or;
  } terms_t;

  // true when a channel's map field carries the given class code
  function automatic logic code_is(input logic [DET_W-1:0] code, input det_e cls);
    return code == cls;
  endfunction

  // only one code picks the second equation; every other code falls back
  function automatic logic mode_is_b(input logic [1:0] mode);
    return mode == LT_B;
  endfunction

  // final trigger equation
  function automatic logic trig_eq(input logic is_b, input logic hit_any,
                                   input logic beta_or, input logic valid_or,
                                   input logic bval);
    logic r;
    if (is_b) r = beta_or & valid_or & hit_any;
    else      r = hit_any & bval;
    return r;
  endfunction
endpackage

// File: rtl/gvt_class_or.sv
module gvt_class_or
  import gvt_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int NUM_PAIRS = NUM_CH / 2
) (
  input  logic [NUM_CH-1:0]       chan_single,
  input  logic [NUM_CH*DET_W-1:0] det_map,
  input  logic [NUM_PAIRS-1:0]    beta_pair,
  output terms_t                  terms
);
  logic [NUM_CH-1:0]    is_beta, is_valid, is_neut;
  logic [NUM_CH-1:0]    beta_hit, valid_hit, neut_hit;
  logic [NUM_PAIRS-1:0] pair_ok, pair_hit;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign is_beta[ch]   = code_is(det_map[ch*DET_W +: DET_W], DET_BETA);
    assign is_valid[ch]  = code_is(det_map[ch*DET_W +: DET_W], DET_VALID);
    assign is_neut[ch]   = code_is(det_map[ch*DET_W +: DET_W], DET_NEUTRON);
    assign beta_hit[ch]  = chan_single[ch] & is_beta[ch];
    assign valid_hit[ch] = chan_single[ch] & is_valid[ch];
    assign neut_hit[ch]  = chan_single[ch] & is_neut[ch];
  end

  // a pair trigger only qualifies when both of its channels are beta
  for (genvar pr = 0; pr < NUM_PAIRS; pr++) begin : g_pair
    assign pair_ok[pr]  = is_beta[2*pr] & is_beta[2*pr+1];
    assign pair_hit[pr] = beta_pair[pr] & pair_ok[pr];
  end

  always_comb begin
    terms.pair_or    = |pair_hit;
    terms.beta_or    = |beta_hit;
    terms.valid_or   = |valid_hit;
    terms.neutron_or = |neut_hit;
    terms.bv_and     = terms.beta_or & terms.valid_or;
  end
endmodule

// File: rtl/gvt_beta_sel.sv
module gvt_beta_sel
  import gvt_pkg::*;
(
  input  logic       pair_or,
  input  logic       beta_or,
  input  logic       bv_and,
  input  logic [1:0] beta_src,
  output logic [2:0] sel_vec,
  output logic       bval
);
  always_comb begin
    unique case (beta_src)
      BS_SINGLE: sel_vec = 3'b010;
      BS_BV_AND: sel_vec = 3'b100;
      default:   sel_vec = 3'b001;  // pair OR, also for the reserved code
    endcase
    bval = (sel_vec[0] & pair_or) | (sel_vec[1] & beta_or) | (sel_vec[2] & bv_and);
  end
endmodule

// File: rtl/gvt_combine.sv
module gvt_combine
  import gvt_pkg::*;
(
  input  logic       coinc_any,
  input  logic       neutron_or,
  input  logic       beta_or,
  input  logic       valid_or,
  input  logic       bval,
  input  logic [1:0] logic_mode,
  output logic       hit_any,
  output logic       use_b,
  output logic       trig_next
);
  always_comb begin
    hit_any   = coinc_any | neutron_or;
    use_b     = mode_is_b(logic_mode);
    trig_next = trig_eq(use_b, hit_any, beta_or, valid_or, bval);
  end
endmodule

// File: rtl/glob_vtrig_gen.sv
module glob_vtrig_gen
  import gvt_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int NUM_CRATES = 4,
  localparam int NUM_PAIRS = NUM_CH / 2,
  localparam int MAP_W     = NUM_CH * DET_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CRATES-1:0] crate_coinc_or,
  input  logic [NUM_CH-1:0]     chan_single,
  input  logic [NUM_PAIRS-1:0]  beta_pair,
  input  logic [MAP_W-1:0]      det_map,
  input  logic [1:0]            logic_mode,
  input  logic [1:0]            beta_src,
  output logic                  global_trig
);
  terms_t     terms;
  logic       coinc_any;
  logic [2:0] sel_vec;
  logic       bval, hit_any, use_b, trig_next;

  assign coinc_any = |crate_coinc_or;

  gvt_class_or #(.NUM_CH(NUM_CH)) u_class (
    .chan_single (chan_single),
    .det_map     (det_map),
    .beta_pair   (beta_pair),
    .terms       (terms)
  );

  gvt_beta_sel u_bsel (
    .pair_or  (terms.pair_or),
    .beta_or  (terms.beta_or),
    .bv_and   (terms.bv_and),
    .beta_src (beta_src),
    .sel_vec  (sel_vec),
    .bval     (bval)
  );

  gvt_combine u_comb (
    .coinc_any  (coinc_any),
    .neutron_or (terms.neutron_or),
    .beta_or    (terms.beta_or),
    .valid_or   (terms.valid_or),
    .bval       (bval),
    .logic_mode (logic_mode),
    .hit_any    (hit_any),
    .use_b      (use_b),
    .trig_next  (trig_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) global_trig <= 1'b0;
    else        global_trig <= trig_next;
  end

  // R5: the selector never enables two sources at once
  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  // R3: a qualified pair term needs some raw pair trigger
  a_r3_pair_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    terms.pair_or |-> (|beta_pair));

  // R6: no coincidence and no neutron means no trigger in the next cycle
  a_r6_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!coinc_any && !terms.neutron_or) |=> !global_trig);

  // R6: in the first equation a missing validation term blocks the trigger
  a_r6_needs_bval: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_b && !bval) |=> !global_trig);

  // R7: the second equation always requires a valid-class hit
  a_r7_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_mode == 2'b01 && !terms.valid_or) |=> !global_trig);

  // R2: the AND term can only be high while the beta OR is high
  a_r2_and_subset: assert property (@(posedge clk) disable iff (!rst_n)
    terms.bv_and |-> terms.beta_or);
endmodule

// File: tb/tb_glob_vtrig_gen.sv
`timescale 1ns/1ps
module tb_glob_vtrig_gen;
  localparam int NCH = 16;
  localparam int NCR = 3;
  localparam int NPR = NCH / 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCR-1:0]   crate_coinc_or = '0;
  logic [NCH-1:0]   chan_single = '0;
  logic [NPR-1:0]   beta_pair = '0;
  logic [NCH*3-1:0] det_map = '0;
  logic [1:0]       logic_mode = 2'b00;
  logic [1:0]       beta_src = 2'b00;
  logic             global_trig;

  int n_checks = 0;
  int n_fail   = 0;
  logic [NCH*3-1:0] base_map;

  always #4 clk = ~clk;

  glob_vtrig_gen #(.NUM_CH(NCH), .NUM_CRATES(NCR)) dut (
    .clk(clk), .rst_n(rst_n), .crate_coinc_or(crate_coinc_or),
    .chan_single(chan_single), .beta_pair(beta_pair), .det_map(det_map),
    .logic_mode(logic_mode), .beta_src(beta_src), .global_trig(global_trig)
  );

  // behavioural reference: count hits per class, then apply the equation
  function automatic bit model(input logic [NCH*3-1:0] m, input logic [1:0] mode,
                               input logic [1:0] src, input logic [NCR-1:0] cr,
                               input logic [NCH-1:0] s, input logic [NPR-1:0] p);
    int nb = 0, nv = 0, nn = 0, np = 0;
    bit hit, bv;
    for (int i = 0; i < NCH; i++) begin
      int code = int'(m[3*i +: 3]);
      if (s[i]) begin
        if (code == 1) nb++;
        if (code == 2) nv++;
        if (code == 3) nn++;
      end
    end
    for (int j = 0; j < NPR; j++)
      if (p[j] && int'(m[6*j +: 3]) == 1 && int'(m[6*j+3 +: 3]) == 1) np++;
    hit = (cr != 0) || (nn > 0);
    case (src)
      2'd1:    bv = nb > 0;
      2'd2:    bv = (nb > 0) && (nv > 0);
      default: bv = np > 0;
    endcase
    if (mode == 2'b01) return (nb > 0) && (nv > 0) && hit;
    return hit && bv;
  endfunction

  task automatic check(input string tag, input bit exp);
    n_checks++;
    if (global_trig !== exp) begin
      n_fail++;
      $display("FAIL %s: global_trig=%b expected=%b", tag, global_trig, exp);
    end
  endtask

  // apply inputs at a falling edge, check one cycle later
  task automatic step(input string tag, input logic [1:0] mode, input logic [1:0] src,
                      input logic [NCR-1:0] cr, input logic [NCH-1:0] s,
                      input logic [NPR-1:0] p);
    bit e;
    logic_mode = mode; beta_src = src; crate_coinc_or = cr;
    chan_single = s; beta_pair = p;
    e = model(det_map, mode, src, cr, s, p);
    @(negedge clk);
    check(tag, e);
  endtask

  initial begin
    // ch0-3 beta, ch4-5 valid, ch6-7 neutron, ch8-11 gamma, ch12 code 5, rest none
    base_map = '0;
    for (int i = 0; i < 4; i++) base_map[3*i +: 3] = 3'd1;
    base_map[12 +: 3] = 3'd2; base_map[15 +: 3] = 3'd2;
    base_map[18 +: 3] = 3'd3; base_map[21 +: 3] = 3'd3;
    for (int i = 8; i < 12; i++) base_map[3*i +: 3] = 3'd4;
    base_map[36 +: 3] = 3'd5;
    det_map = base_map;
    // the whole input set would fire if reset were ignored
    crate_coinc_or = 3'b001; chan_single = 16'h0031; beta_pair = 8'h01;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    crate_coinc_or = '0; chan_single = '0; beta_pair = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0);

    // R1 latency: no change before the edge, change after it
    logic_mode = 2'b00; beta_src = 2'd1; crate_coinc_or = 3'b001; chan_single = 16'h0001;
    #1 check("R1 before edge", 1'b0);
    @(negedge clk);
    check("R1 one cycle", 1'b1);

    // R4: each crate alone raises the coincidence term
    step("R4 crate0", 2'b00, 2'd1, 3'b001, 16'h0002, '0);
    step("R4 crate1", 2'b00, 2'd1, 3'b010, 16'h0002, '0);
    step("R4 crate2", 2'b00, 2'd1, 3'b100, 16'h0002, '0);
    step("R4 none",   2'b00, 2'd1, 3'b000, 16'h0002, '0);

    // R5: source selection
    step("R5 pair src", 2'b00, 2'd0, 3'b001, 16'h0000, 8'h01);
    step("R5 pair src no pair", 2'b00, 2'd0, 3'b001, 16'h0001, 8'h00);
    step("R5 single src", 2'b00, 2'd1, 3'b001, 16'h0004, 8'h00);
    step("R5 and src beta only", 2'b00, 2'd2, 3'b001, 16'h0004, 8'h00);
    step("R5 and src both", 2'b00, 2'd2, 3'b001, 16'h0014, 8'h00);
    step("R5 rsv src as pair", 2'b00, 2'd3, 3'b001, 16'h0000, 8'h02);
    step("R5 rsv src not single", 2'b00, 2'd3, 3'b001, 16'h0001, 8'h00);

    // R3: pair 2 covers valid channels, so it is masked
    step("R3 masked pair", 2'b00, 2'd0, 3'b001, 16'h0000, 8'h04);
    det_map = base_map; det_map[3 +: 3] = 3'd4;  // ch1 gamma breaks pair 0
    step("R3 half beta pair", 2'b00, 2'd0, 3'b001, 16'h0000, 8'h01);
    det_map = base_map;

    // R6: neutron replaces coincidence
    step("R6 neutron hit", 2'b00, 2'd1, 3'b000, 16'h0041, '0);
    step("R6 neutron no beta", 2'b00, 2'd1, 3'b000, 16'h0040, '0);

    // R9: gamma, none and reserved channels have no effect
    step("R9 gamma as neutron", 2'b00, 2'd1, 3'b000, 16'h0F01, '0);
    step("R9 reserved as beta", 2'b00, 2'd1, 3'b001, 16'h1000, '0);
    step("R9 none as valid", 2'b01, 2'd0, 3'b001, 16'hE001, '0);

    // R7: second equation
    step("R7 full", 2'b01, 2'd0, 3'b001, 16'h0011, 8'h00);
    step("R7 no valid", 2'b01, 2'd1, 3'b001, 16'h0001, 8'h00);
    step("R7 src ignored", 2'b01, 2'd3, 3'b000, 16'h0051, 8'h00);
    step("R7 no hit", 2'b01, 2'd1, 3'b000, 16'h0011, 8'h00);

    // R8: other codes behave as the first equation
    step("R8 code10", 2'b10, 2'd1, 3'b001, 16'h0001, '0);
    step("R8 code11", 2'b11, 2'd1, 3'b001, 16'h0001, '0);
    step("R8 code10 no valid need", 2'b10, 2'd0, 3'b010, 16'h0000, 8'h02);

    // varied patterns, R2 class map in effect throughout
    for (int k = 0; k < 400; k++) begin
      logic [1:0] md = 2'($urandom_range(0, 3));
      step(md == 2'b01 ? "R7 varied" : "R2 R8 varied", md, 2'($urandom_range(0, 3)),
           NCR'($urandom & $urandom), NCH'($urandom & $urandom), NPR'($urandom));
    end

    // R1: reset again clears the output
    step("R6 set", 2'b00, 2'd1, 3'b001, 16'h0001, '0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog: actual=hang expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule